// File: doc/BRIEF.md
# Programmable Priority Interrupt Arbiter

The arbiter collects interrupt requests from a parameterised number of channels. Each channel carries a 3-bit priority that software programs, where a lower value means a more urgent channel. On every arbitration strobe the arbiter finds the most urgent pending channel. It grants that channel only if its priority value is strictly below the running CPU level. When several channels share the best value, the one with the lowest index wins, because the lowest index sits first in a fixed chain.

When a request is granted, the arbiter saves the running level on a nesting stack and adopts the channel's priority as the new level. It also presents a one-cycle acknowledge together with the channel index. A return pulse restores the saved level. A separate top-level source can be set as maskable or non-maskable. It beats every channel whatever the running level is, and while it is in service no further grant can happen. Software can read and write the running level at any time through a simple write strobe and a read port.

Top module: `irq_prio_arbiter`

## Requirements
- R1: After reset the running level reads 7, the stack depth is 0, ack_o, in_top_o and pop_err_o are low, and every channel priority is 7.
- R2: A cycle with lvl_we_i high and no grant or return loads lvl_wdata_i into the running level, which appears on lvl_o after that clock edge.
- R3: A channel is granted only when its priority value is strictly less than the running level; an equal value is not granted.
- R4: A channel programmed to priority 7 is never granted and stays pending.
- R5: Among pending channels the one with the smallest priority value wins.
- R6: Among pending channels with the same smallest value, the lowest channel index wins.
- R7: A granted strobe gives, one cycle later, ack_o high for one cycle, ack_top_o low, ack_id_o equal to the channel index, lvl_o equal to that channel's priority and depth_o one higher. The channel's pending request is cleared.
- R8: A reti_i pulse with depth above 0 restores the level saved by the matching grant and lowers depth_o by one.
- R9: A reti_i pulse at depth 0 leaves the level unchanged and raises pop_err_o for exactly one cycle.
- R10: A pending top-level request that is enabled is granted at the next strobe even when the running level is 0. It drives ack_o and ack_top_o high, sets in_top_o, keeps the level and raises the depth by one.
- R11: While in_top_o is high no grant of any kind occurs; the next return clears in_top_o.
- R12: With top_nmi_i low, the top-level request waits while top_en_i is low. It is granted once top_en_i is high. With top_nmi_i high, top_en_i has no effect.
- R13: At depth 8 no grant occurs and the depth stays 8.
- R14: Grants happen only on cycles with phase_i high; a cycle with reti_i high grants nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | NUM_CH | Request pulses, one per channel, latched as pending |
| prio_we_i | input | 1 | Write strobe for a channel priority |
| prio_sel_i | input | CH_W | Channel whose priority is written |
| prio_wdata_i | input | 3 | Priority value to write |
| lvl_we_i | input | 1 | Write strobe for the running level |
| lvl_wdata_i | input | 3 | Running level value to write |
| lvl_o | output | 3 | Running level |
| top_req_i | input | 1 | Top-level request pulse, latched as pending |
| top_nmi_i | input | 1 | 1: top level cannot be masked |
| top_en_i | input | 1 | Enable of a maskable top level |
| phase_i | input | 1 | Arbitration strobe, once per instruction |
| reti_i | input | 1 | Return from service routine |
| ack_o | output | 1 | One-cycle grant acknowledge |
| ack_top_o | output | 1 | Grant was for the top-level source |
| ack_id_o | output | CH_W | Granted channel index (0 on a top-level grant) |
| in_top_o | output | 1 | Top-level routine in service |
| depth_o | output | CNT_W | Current nesting depth |
| pop_err_o | output | 1 | One-cycle flag for a return at depth 0 |

## Verification
The selection logic is tried with one lone pending channel, and the priority is tested both equal to and just below the running level, which tells a strict comparison from a non-strict one. Mixed priority values show whether the smallest value wins, and equal values on two channels show whether the lowest index wins. Pending requests are kept across several returns, so the bench can see that they survive level changes. A chain of seven strictly rising grants followed by a software lowering of the level fills the stack to its limit. The top-level source is tried at level 0, with masking on and off, and with a channel raised during its service.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int LVL_W = 3;
  typedef logic [LVL_W-1:0] lvl_t;
  localparam lvl_t LVL_LOWEST = lvl_t'(7);
endpackage

// File: rtl/irq_req_bank.sv
module irq_req_bank
  import irq_arb_pkg::*;
#(
  parameter int NUM_CH = 16,
  localparam int CH_W = $clog2(NUM_CH)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_CH-1:0]      req_i,
  input  logic                   prio_we_i,
  input  logic [CH_W-1:0]        prio_sel_i,
  input  lvl_t                   prio_wdata_i,
  input  logic                   clr_i,
  input  logic [CH_W-1:0]        clr_id_i,
  output logic [NUM_CH-1:0]      pend_o,
  output logic [NUM_CH-1:0][LVL_W-1:0] prio_o
);

  logic [NUM_CH-1:0]            pend_q, pend_d;
  logic [NUM_CH-1:0][LVL_W-1:0] prio_q, prio_d;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    always_comb begin
      pend_d[i] = pend_q[i];
      if (clr_i && (clr_id_i == CH_W'(i))) pend_d[i] = 1'b0;
      if (req_i[i]) pend_d[i] = 1'b1;
      prio_d[i] = prio_q[i];
      if (prio_we_i && (prio_sel_i == CH_W'(i))) prio_d[i] = prio_wdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend_q[i] <= 1'b0;
        prio_q[i] <= LVL_LOWEST;
      end else begin
        pend_q[i] <= pend_d[i];
        prio_q[i] <= prio_d[i];
      end
    end
  end

  assign pend_o = pend_q;
  assign prio_o = prio_q;

endmodule

// File: rtl/irq_win_select.sv
module irq_win_select
  import irq_arb_pkg::*;
#(
  parameter int NUM_CH = 16,
  localparam int CH_W = $clog2(NUM_CH)
) (
  input  logic [NUM_CH-1:0]            pend_i,
  input  logic [NUM_CH-1:0][LVL_W-1:0] prio_i,
  output logic                         win_valid_o,
  output logic [CH_W-1:0]              win_id_o,
  output lvl_t                         win_prio_o
);

  // Chain of stages; a later stage takes over only with a strictly
  // smaller value, so ties stay with the lower index.
  logic [NUM_CH:0] stg_v;
  lvl_t            stg_p  [NUM_CH+1];
  logic [CH_W-1:0] stg_id [NUM_CH+1];

  assign stg_v[0]  = 1'b0;
  assign stg_p[0]  = LVL_LOWEST;
  assign stg_id[0] = '0;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_stage
    logic take;
    assign take         = pend_i[i] && (!stg_v[i] || (prio_i[i] < stg_p[i]));
    assign stg_v[i+1]   = stg_v[i] | pend_i[i];
    assign stg_p[i+1]   = take ? prio_i[i] : stg_p[i];
    assign stg_id[i+1]  = take ? CH_W'(i) : stg_id[i];
  end

  assign win_valid_o = stg_v[NUM_CH];
  assign win_prio_o  = stg_p[NUM_CH];
  assign win_id_o    = stg_id[NUM_CH];

endmodule

// File: rtl/irq_nest_stack.sv
module irq_nest_stack
  import irq_arb_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_i,
  input  lvl_t             push_lvl_i,
  input  logic             pop_i,
  input  logic             wr_i,
  input  lvl_t             wr_lvl_i,
  output lvl_t             lvl_o,
  output logic [CNT_W-1:0] depth_o,
  output logic             pop_err_o
);

  lvl_t             stk_q [DEPTH];
  lvl_t             lvl_q, lvl_d;
  logic [CNT_W-1:0] depth_q, depth_d;
  logic             err_q, err_d;
  logic [IDX_W-1:0] rd_idx, wr_idx;
  logic             do_push;

  assign rd_idx  = IDX_W'(depth_q - 1'b1);
  assign wr_idx  = IDX_W'(depth_q);
  assign do_push = push_i && !pop_i;

  always_comb begin
    lvl_d   = lvl_q;
    depth_d = depth_q;
    err_d   = 1'b0;
    if (pop_i) begin
      if (depth_q == '0) begin
        err_d = 1'b1;
      end else begin
        depth_d = depth_q - 1'b1;
        lvl_d   = stk_q[rd_idx];
      end
    end else if (push_i) begin
      depth_d = depth_q + 1'b1;
      lvl_d   = push_lvl_i;
    end else if (wr_i) begin
      lvl_d = wr_lvl_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q   <= LVL_LOWEST;
      depth_q <= '0;
      err_q   <= 1'b0;
    end else begin
      lvl_q   <= lvl_d;
      depth_q <= depth_d;
      err_q   <= err_d;
    end
  end

  // Saved levels carry no reset; a slot is only read after it is written.
  always_ff @(posedge clk) begin
    if (do_push) stk_q[wr_idx] <= lvl_q;
  end

  assign lvl_o     = lvl_q;
  assign depth_o   = depth_q;
  assign pop_err_o = err_q;

endmodule

// File: rtl/irq_prio_arbiter.sv
module irq_prio_arbiter
  import irq_arb_pkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int DEPTH = 8,
  localparam int CH_W = $clog2(NUM_CH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] req_i,
  input  logic              prio_we_i,
  input  logic [CH_W-1:0]   prio_sel_i,
  input  logic [2:0]        prio_wdata_i,
  input  logic              lvl_we_i,
  input  logic [2:0]        lvl_wdata_i,
  output logic [2:0]        lvl_o,
  input  logic              top_req_i,
  input  logic              top_nmi_i,
  input  logic              top_en_i,
  input  logic              phase_i,
  input  logic              reti_i,
  output logic              ack_o,
  output logic              ack_top_o,
  output logic [CH_W-1:0]   ack_id_o,
  output logic              in_top_o,
  output logic [CNT_W-1:0]  depth_o,
  output logic              pop_err_o
);

  logic [NUM_CH-1:0]            pend;
  logic [NUM_CH-1:0][LVL_W-1:0] prio;
  logic                         win_valid;
  logic [CH_W-1:0]              win_id;
  lvl_t                         win_prio;
  lvl_t                         cur_lvl;
  logic [CNT_W-1:0]             depth;
  logic                         full, may_grant, top_ok, nrm_ok, push;
  lvl_t                         push_lvl;

  logic            top_pend_q, top_pend_d;
  logic            in_top_q, in_top_d;
  logic            ack_q, ack_top_q;
  logic [CH_W-1:0] ack_id_q, ack_id_d;

  irq_req_bank #(.NUM_CH(NUM_CH)) u_bank (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_i        (req_i),
    .prio_we_i    (prio_we_i),
    .prio_sel_i   (prio_sel_i),
    .prio_wdata_i (prio_wdata_i),
    .clr_i        (nrm_ok),
    .clr_id_i     (win_id),
    .pend_o       (pend),
    .prio_o       (prio)
  );

  irq_win_select #(.NUM_CH(NUM_CH)) u_sel (
    .pend_i      (pend),
    .prio_i      (prio),
    .win_valid_o (win_valid),
    .win_id_o    (win_id),
    .win_prio_o  (win_prio)
  );

  irq_nest_stack #(.DEPTH(DEPTH)) u_stack (
    .clk        (clk),
    .rst_n      (rst_n),
    .push_i     (push),
    .push_lvl_i (push_lvl),
    .pop_i      (reti_i),
    .wr_i       (lvl_we_i),
    .wr_lvl_i   (lvl_wdata_i),
    .lvl_o      (cur_lvl),
    .depth_o    (depth),
    .pop_err_o  (pop_err_o)
  );

  // Grant decision: top level first, then the best channel under a
  // strict comparison with the running level.
  always_comb begin
    full      = (depth == CNT_W'(DEPTH));
    may_grant = phase_i && !reti_i && !in_top_q && !full;
    top_ok    = may_grant && top_pend_q && (top_nmi_i || top_en_i);
    nrm_ok    = may_grant && !top_ok && win_valid && (win_prio < cur_lvl);
    push      = top_ok || nrm_ok;
    push_lvl  = top_ok ? cur_lvl : win_prio;
  end

  always_comb begin
    top_pend_d = (top_pend_q && !top_ok) || top_req_i;
    in_top_d   = in_top_q;
    if (reti_i && (depth != '0)) in_top_d = 1'b0;
    if (top_ok) in_top_d = 1'b1;
    ack_id_d   = nrm_ok ? win_id : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      top_pend_q <= 1'b0;
      in_top_q   <= 1'b0;
      ack_q      <= 1'b0;
      ack_top_q  <= 1'b0;
      ack_id_q   <= '0;
    end else begin
      top_pend_q <= top_pend_d;
      in_top_q   <= in_top_d;
      ack_q      <= push;
      ack_top_q  <= top_ok;
      ack_id_q   <= ack_id_d;
    end
  end

  assign lvl_o     = cur_lvl;
  assign depth_o   = depth;
  assign ack_o     = ack_q;
  assign ack_top_o = ack_top_q;
  assign ack_id_o  = ack_id_q;
  assign in_top_o  = in_top_q;

endmodule

// File: rtl/irq_prio_arbiter_chk.sv
module irq_prio_arbiter_chk #(
  parameter int DEPTH = 8,
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             phase_i,
  input logic             reti_i,
  input logic             ack_o,
  input logic             ack_top_o,
  input logic [2:0]       lvl_o,
  input logic             in_top_o,
  input logic [CNT_W-1:0] depth_o,
  input logic             pop_err_o
);

  // R7
  normal_ack_raises_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_o && !ack_top_o) |-> (lvl_o < $past(lvl_o)));

  // R7
  ack_depth_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |-> (depth_o == $past(depth_o) + 1'b1));

  // R13
  depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    depth_o <= CNT_W'(DEPTH));

  // R11
  top_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_top_o) |-> !ack_o);

  // R9
  pop_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop_err_o |-> ($past(depth_o) == '0) && $stable(lvl_o));

  // R14
  phase_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |-> ($past(phase_i) && !$past(reti_i)));

  // R10
  top_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_top_o |-> (ack_o && in_top_o));

endmodule

bind irq_prio_arbiter irq_prio_arbiter_chk #(
  .DEPTH (DEPTH),
  .CNT_W (CNT_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .phase_i   (phase_i),
  .reti_i    (reti_i),
  .ack_o     (ack_o),
  .ack_top_o (ack_top_o),
  .lvl_o     (lvl_o),
  .in_top_o  (in_top_o),
  .depth_o   (depth_o),
  .pop_err_o (pop_err_o)
);

// File: tb/irq_prio_arbiter_bench.sv
module irq_prio_arbiter_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_CH = 16;
  localparam int DEPTH = 8;
  localparam int CH_W = 4;
  localparam int CNT_W = 4;

  logic              clk;
  logic              rst_n;
  logic [NUM_CH-1:0] req_i;
  logic              prio_we_i;
  logic [CH_W-1:0]   prio_sel_i;
  logic [2:0]        prio_wdata_i;
  logic              lvl_we_i;
  logic [2:0]        lvl_wdata_i;
  logic [2:0]        lvl_o;
  logic              top_req_i, top_nmi_i, top_en_i, phase_i, reti_i;
  logic              ack_o, ack_top_o, in_top_o, pop_err_o;
  logic [CH_W-1:0]   ack_id_o;
  logic [CNT_W-1:0]  depth_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  irq_prio_arbiter #(.NUM_CH(NUM_CH), .DEPTH(DEPTH)) u_irq_prio_arbiter (
    .clk(clk), .rst_n(rst_n), .req_i(req_i),
    .prio_we_i(prio_we_i), .prio_sel_i(prio_sel_i), .prio_wdata_i(prio_wdata_i),
    .lvl_we_i(lvl_we_i), .lvl_wdata_i(lvl_wdata_i), .lvl_o(lvl_o),
    .top_req_i(top_req_i), .top_nmi_i(top_nmi_i), .top_en_i(top_en_i),
    .phase_i(phase_i), .reti_i(reti_i),
    .ack_o(ack_o), .ack_top_o(ack_top_o), .ack_id_o(ack_id_o),
    .in_top_o(in_top_o), .depth_o(depth_o), .pop_err_o(pop_err_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    summary();
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic set_prio(input int ch, input int p);
    prio_we_i = 1; prio_sel_i = CH_W'(ch); prio_wdata_i = 3'(p);
    step();
    prio_we_i = 0;
  endtask

  task automatic set_lvl(input int v);
    lvl_we_i = 1; lvl_wdata_i = 3'(v);
    step();
    lvl_we_i = 0;
  endtask

  task automatic pulse_req(input logic [NUM_CH-1:0] m);
    req_i = m;
    step();
    req_i = '0;
  endtask

  task automatic strobe();
    phase_i = 1;
    step();
    phase_i = 0;
  endtask

  task automatic do_reti();
    reti_i = 1;
    step();
    reti_i = 0;
  endtask

  task automatic t_reset();
    chk("R1 level", lvl_o, 7);
    chk("R1 depth", depth_o, 0);
    chk("R1 ack", ack_o, 0);
    chk("R1 in_top", in_top_o, 0);
    chk("R1 pop_err", pop_err_o, 0);
    pulse_req(16'h0008);
    strobe();
    chk("R1 R4 default prio 7 not granted", ack_o, 0);
    set_lvl(7);
    strobe();
    chk("R4 level 7 channel still not granted", ack_o, 0);
  endtask

  task automatic t_level_rw();
    set_lvl(5);
    chk("R2 level write", lvl_o, 5);
    set_lvl(7);
    chk("R2 level write back", lvl_o, 7);
  endtask

  task automatic t_strict();
    set_prio(2, 4);
    set_lvl(4);
    pulse_req(16'h0004);
    strobe();
    chk("R3 equal level not granted", ack_o, 0);
    set_lvl(5);
    strobe();
    chk("R3 R7 ack", ack_o, 1);
    chk("R7 ack_top low", ack_top_o, 0);
    chk("R7 ack id", ack_id_o, 2);
    chk("R7 level", lvl_o, 4);
    chk("R7 depth", depth_o, 1);
    step();
    chk("R7 ack one cycle", ack_o, 0);
    do_reti();
    chk("R8 level restored", lvl_o, 5);
    chk("R8 depth", depth_o, 0);
    set_lvl(7);
    strobe();
    chk("R7 pending cleared", ack_o, 0);
  endtask

  task automatic t_best();
    set_prio(1, 6); set_prio(9, 2); set_prio(5, 3);
    pulse_req(16'h0222);
    strobe();
    chk("R5 smallest value wins", ack_id_o, 9);
    chk("R5 level", lvl_o, 2);
    strobe();
    chk("R3 value 3 above level 2", ack_o, 0);
    do_reti();
    chk("R8 level back to 7", lvl_o, 7);
    strobe();
    chk("R5 next best", ack_id_o, 5);
    do_reti();
    strobe();
    chk("R5 last", ack_id_o, 1);
    do_reti();
  endtask

  task automatic t_tie();
    set_prio(4, 2); set_prio(11, 2);
    pulse_req(16'h0810);
    strobe();
    chk("R6 lower index wins", ack_id_o, 4);
    do_reti();
    strobe();
    chk("R6 other one next", ack_id_o, 11);
    do_reti();
  endtask

  task automatic t_empty_pop();
    do_reti();
    chk("R9 pop_err", pop_err_o, 1);
    chk("R9 level unchanged", lvl_o, 7);
    chk("R9 depth", depth_o, 0);
    step();
    chk("R9 pop_err one cycle", pop_err_o, 0);
  endtask

  task automatic t_top();
    set_lvl(0);
    top_nmi_i = 1;
    top_req_i = 1; step(); top_req_i = 0;
    strobe();
    chk("R10 ack", ack_o, 1);
    chk("R10 ack_top", ack_top_o, 1);
    chk("R10 in_top", in_top_o, 1);
    chk("R10 level kept", lvl_o, 0);
    chk("R10 depth", depth_o, 1);
    set_prio(0, 1);
    set_lvl(7);
    pulse_req(16'h0001);
    strobe();
    chk("R11 no grant in top", ack_o, 0);
    do_reti();
    chk("R11 in_top cleared", in_top_o, 0);
    chk("R8 level restored after top", lvl_o, 0);
    set_lvl(7);
    strobe();
    chk("R11 channel served after top", ack_id_o, 0);
    chk("R11 ack after top", ack_o, 1);
    do_reti();
  endtask

  task automatic t_mask();
    top_nmi_i = 0; top_en_i = 0;
    top_req_i = 1; step(); top_req_i = 0;
    strobe();
    chk("R12 masked top waits", ack_o, 0);
    top_en_i = 1;
    strobe();
    chk("R12 enabled top granted", ack_top_o, 1);
    do_reti();
    top_en_i = 0;
    chk("R12 depth back", depth_o, 0);
  endtask

  task automatic t_depth();
    for (int i = 0; i < 7; i++) begin
      set_prio(i, 6 - i);
      pulse_req(NUM_CH'(1) << i);
      strobe();
      chk("R13 chain grant", ack_id_o, i);
    end
    chk("R13 depth 7", depth_o, 7);
    set_lvl(7);
    set_prio(7, 3);
    pulse_req(16'h0080);
    strobe();
    chk("R13 eighth grant", ack_o, 1);
    chk("R13 depth 8", depth_o, 8);
    set_lvl(7);
    set_prio(8, 3);
    pulse_req(16'h0100);
    strobe();
    chk("R13 full blocks grant", ack_o, 0);
    chk("R13 depth stays 8", depth_o, 8);
    do_reti();
    chk("R8 pop restores written level", lvl_o, 7);
    for (int i = 0; i < 7; i++) do_reti();
    chk("R8 depth empty", depth_o, 0);
    chk("R8 original level", lvl_o, 7);
    strobe();
    chk("R13 held request served", ack_id_o, 8);
    do_reti();
  endtask

  task automatic t_phase();
    set_prio(12, 1);
    pulse_req(16'h1000);
    for (int i = 0; i < 3; i++) begin
      step();
      chk("R14 no grant without strobe", ack_o, 0);
    end
    phase_i = 1; reti_i = 1;
    step();
    phase_i = 0; reti_i = 0;
    chk("R14 reti suppresses grant", ack_o, 0);
    chk("R9 pop_err with strobe", pop_err_o, 1);
    strobe();
    chk("R14 grant on strobe", ack_id_o, 12);
    do_reti();
  endtask

  initial begin
    rst_n = 0;
    req_i = '0; prio_we_i = 0; prio_sel_i = '0; prio_wdata_i = '0;
    lvl_we_i = 0; lvl_wdata_i = '0;
    top_req_i = 0; top_nmi_i = 0; top_en_i = 0; phase_i = 0; reti_i = 0;
    repeat (3) step();
    rst_n = 1;
    step();
    t_reset();
    t_level_rw();
    t_strict();
    t_best();
    t_tie();
    t_empty_pop();
    t_top();
    t_mask();
    t_depth();
    t_phase();
    step();
    summary();
  end

endmodule